// File: doc/BRIEF.md
# Four-Channel DAC Command Register Bank

This block sits behind a serial front end and turns already validated command words into register state for a four-channel, 16-bit digital-to-analog converter. Each channel has two registers. The staging register collects new codes. The live register holds the code that the converter actually outputs. A channel also has a power-down flag and a 2-bit termination mode. The block carries out the per-channel write and load commands, a set of broadcast commands and a hardware load strobe. It also captures a readback word for the front end to shift out.

The front end checks the two device-address bits of each frame and removes them. It then presents the remaining 22 bits on `cmd_word`, reports the comparison on `addr_hit` and pulses `cmd_stb` once for each complete frame. It pulses `hdr_stb` once the channel-select bits of a frame have arrived, which is eight bits into the frame. The load strobe `load_pin` is asynchronous. Its rising edges copy every staging register into its live register.

Top module: `dac_cmd_bank`

## Requirements
- R1: After reset every live code, staging code, termination mode and readback word is zero, no channel is powered down and the serial output enable is low.
- R2: When `cmd_word[21:20]`=00, a write stores `cmd_word[15:0]` into the staging register of the channel selected by `cmd_word[18:17]` (00=A, 01=B, 10=C, 11=D). All live codes stay unchanged.
- R3: When `cmd_word[21:20]`=01, a write stores the data into the selected channel's staging register and also into its live register, one cycle after `cmd_stb`.
- R4: When `cmd_word[21:20]`=10, a write stores the data into the selected staging register. Every channel's live register then takes its staging value, including the data just written.
- R5: With load-select 00, 01 or 10, a command is ignored when `addr_hit` is low. With load-select 00 or 01, bit 19 set marks a read, which changes no state. With load-select 10, bit 19 is ignored and the command is a write.
- R6: A non-broadcast write with bit 16 set powers down only the selected channel and stores `cmd_word[15:14]` as its termination mode. Staging and live codes are untouched.
- R7: Any update of a channel's live register clears that channel's power-down flag.
- R8: Load-select 11 is a broadcast and is executed regardless of `addr_hit`. The broadcast operation is chosen by `cmd_word[18:17]`. With 00, every live register loads from its staging register. With 01, the data is written into every staging and every live register.
- R9: A broadcast with `cmd_word[18:17]`=10 powers down all four channels and gives them all the mode in `cmd_word[15:14]`.
- R10: A broadcast with `cmd_word[18:17]`=11 sets the serial output enable to `cmd_word[16]`.
- R11: A rising edge on `load_pin` copies every staging register into its live register and clears all power-down flags. This takes effect on the third clock edge after the pin is first sampled high. If a command executes in that same cycle, the command is applied first and the copy second.
- R12: When `hdr_stb` is high, `rd_data` takes the live code of the channel selected by `cmd_word[18:17]` on the next clock edge. A command executing in the same cycle does not affect the captured value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 22 | Frame without address bits: [21:20] load-select, [19] read, [18:17] channel/op, [16] power-down, [15:0] data |
| cmd_stb | input | 1 | Execute the command on `cmd_word` this cycle |
| addr_hit | input | 1 | Device address of the frame matched |
| hdr_stb | input | 1 | Capture the readback word for the channel in `cmd_word[18:17]` |
| load_pin | input | 1 | Asynchronous hardware load strobe, rising-edge active |
| act_code | output | 64 | Live codes, channel A in bits 15:0 up to D in 63:48 |
| pd_on | output | 4 | Power-down flag per channel, bit 0 = A |
| pd_mode | output | 8 | Termination mode per channel, 2 bits each, A lowest |
| spi_out_en | output | 1 | Serial output function enabled |
| rd_data | output | 16 | Captured readback word |

## Verification
On every cycle the assertions check the following:
- A synchronized load edge leaves each live register equal to its staging register, with no channel powered down.
- The state holds while nothing executes.
- Address-mismatched and read commands leave the codes alone.
- The power-down and serial-enable broadcasts take the commanded values.
- Readback returns the live code that was present at the header.

Only the bench's scenarios can show the following:
- Which channel a select code reaches, and that the live registers ignore a load-select 00 write until the next load.
- The three-edge latency of the load pin.
- The ordering when a load edge and a command land in the same cycle.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  localparam int CODE_W  = 16;
  localparam int SEL_W   = 2;
  localparam int MODE_W  = 2;
  localparam int CMD_W   = 22;

  typedef enum logic [1:0] {
    LS_STAGE  = 2'b00,
    LS_ONE    = 2'b01,
    LS_ALL    = 2'b10,
    LS_BCAST  = 2'b11
  } load_sel_e;

  typedef enum logic [1:0] {
    BC_FROM_STAGE = 2'b00,
    BC_DATA_ALL   = 2'b01,
    BC_PWRDN_ALL  = 2'b10,
    BC_SPI_OUT    = 2'b11
  } bcast_op_e;

  typedef struct packed {
    load_sel_e             ls;
    logic                  rd;
    logic [SEL_W-1:0]      sel;
    logic                  pd;
    logic [CODE_W-1:0]     data;
  } cmd_t;

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
#(
  parameter int CH_N = 4
) (
  input  logic                cmd_stb,
  input  logic                addr_hit,
  input  cmd_t                cmd,
  output logic [CH_N-1:0]     wr_stage,
  output logic [CH_N-1:0]     ld_data,
  output logic [CH_N-1:0]     ld_stage,
  output logic [CH_N-1:0]     pd_set,
  output logic [MODE_W-1:0]   pd_mode_new,
  output logic [CODE_W-1:0]   wr_code,
  output logic                spi_wr,
  output logic                spi_val
);

  logic [CH_N-1:0] sel_oh;
  logic            is_read;

  always_comb begin
    for (int i = 0; i < CH_N; i++) begin
      sel_oh[i] = (cmd.sel == SEL_W'(i));
    end
  end

  assign is_read     = cmd.rd && ((cmd.ls == LS_STAGE) || (cmd.ls == LS_ONE));
  assign pd_mode_new = cmd.data[CODE_W-1 -: MODE_W];
  assign wr_code     = cmd.data;

  always_comb begin
    wr_stage = '0;
    ld_data  = '0;
    ld_stage = '0;
    pd_set   = '0;
    spi_wr   = 1'b0;
    spi_val  = 1'b0;
    if (cmd_stb) begin
      if (cmd.ls == LS_BCAST) begin
        case (bcast_op_e'(cmd.sel))
          BC_FROM_STAGE: ld_stage = '1;
          BC_DATA_ALL: begin
            wr_stage = '1;
            ld_data  = '1;
          end
          BC_PWRDN_ALL:  pd_set = '1;
          default: begin
            spi_wr  = 1'b1;
            spi_val = cmd.pd;
          end
        endcase
      end else if (addr_hit && !is_read) begin
        if (cmd.pd) begin
          pd_set = sel_oh;
        end else begin
          wr_stage = sel_oh;
          if (cmd.ls == LS_ONE) begin
            ld_data = sel_oh;
          end else if (cmd.ls == LS_ALL) begin
            ld_data  = sel_oh;
            ld_stage = ~sel_oh;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dac_chan_slice.sv
module dac_chan_slice
  import dac_cmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stage,
  input  logic                ld_data,
  input  logic                ld_stage,
  input  logic                pd_set,
  input  logic [MODE_W-1:0]   pd_mode_new,
  input  logic [CODE_W-1:0]   wr_code,
  input  logic                load_copy,
  output logic [CODE_W-1:0]   stage_q,
  output logic [CODE_W-1:0]   live_q,
  output logic                pd_q,
  output logic [MODE_W-1:0]   mode_q
);

  logic [CODE_W-1:0] stage_d;
  logic [CODE_W-1:0] live_d;
  logic              pd_d;
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    stage_d = wr_stage ? wr_code : stage_q;
    live_d  = live_q;
    pd_d    = pd_q;
    mode_d  = pd_set ? pd_mode_new : mode_q;
    if (pd_set) begin
      pd_d = 1'b1;
    end
    if (ld_data) begin
      live_d = wr_code;
      pd_d   = 1'b0;
    end else if (ld_stage) begin
      live_d = stage_q;
      pd_d   = 1'b0;
    end
    // the hardware load acts after the command of the same cycle
    if (load_copy) begin
      live_d = stage_d;
      pd_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
      pd_q    <= 1'b0;
      mode_q  <= '0;
    end else begin
      stage_q <= stage_d;
      live_q  <= live_d;
      pd_q    <= pd_d;
      mode_q  <= mode_d;
    end
  end

endmodule

// File: rtl/load_pin_sync.sv
module load_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/dac_cmd_bank.sv
module dac_cmd_bank
  import dac_cmd_pkg::*;
#(
  parameter int CH_N        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CMD_W-1:0]          cmd_word,
  input  logic                      cmd_stb,
  input  logic                      addr_hit,
  input  logic                      hdr_stb,
  input  logic                      load_pin,
  output logic [CH_N*CODE_W-1:0]    act_code,
  output logic [CH_N-1:0]           pd_on,
  output logic [CH_N*MODE_W-1:0]    pd_mode,
  output logic                      spi_out_en,
  output logic [CODE_W-1:0]         rd_data
);

  cmd_t                cmd;
  logic [CH_N-1:0]     wr_stage;
  logic [CH_N-1:0]     ld_data;
  logic [CH_N-1:0]     ld_stage;
  logic [CH_N-1:0]     pd_set;
  logic [MODE_W-1:0]   pd_mode_new;
  logic [CODE_W-1:0]   wr_code;
  logic                spi_wr;
  logic                spi_val;
  logic                load_edge;
  logic [CODE_W-1:0]   live_arr [CH_N];
  logic [CH_N*CODE_W-1:0] stage_flat;
  logic                spi_d;
  logic [CODE_W-1:0]   rd_d;

  assign cmd = cmd_t'(cmd_word);

  dac_cmd_decode #(.CH_N(CH_N)) u_dec (
    .cmd_stb     (cmd_stb),
    .addr_hit    (addr_hit),
    .cmd         (cmd),
    .wr_stage    (wr_stage),
    .ld_data     (ld_data),
    .ld_stage    (ld_stage),
    .pd_set      (pd_set),
    .pd_mode_new (pd_mode_new),
    .wr_code     (wr_code),
    .spi_wr      (spi_wr),
    .spi_val     (spi_val)
  );

  load_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (load_pin),
    .rise  (load_edge)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    dac_chan_slice u_slice (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stage    (wr_stage[g]),
      .ld_data     (ld_data[g]),
      .ld_stage    (ld_stage[g]),
      .pd_set      (pd_set[g]),
      .pd_mode_new (pd_mode_new),
      .wr_code     (wr_code),
      .load_copy   (load_edge),
      .stage_q     (stage_flat[g*CODE_W +: CODE_W]),
      .live_q      (live_arr[g]),
      .pd_q        (pd_on[g]),
      .mode_q      (pd_mode[g*MODE_W +: MODE_W])
    );
    assign act_code[g*CODE_W +: CODE_W] = live_arr[g];
  end

  always_comb begin
    spi_d = spi_wr ? spi_val : spi_out_en;
    rd_d  = hdr_stb ? live_arr[cmd.sel] : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_out_en <= 1'b0;
      rd_data    <= '0;
    end else begin
      spi_out_en <= spi_d;
      rd_data    <= rd_d;
    end
  end

endmodule

// File: rtl/dac_cmd_bank_chk.sv
module dac_cmd_bank_chk
  import dac_cmd_pkg::*;
#(
  parameter int CH_N = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CMD_W-1:0]        cmd_word,
  input logic                    cmd_stb,
  input logic                    addr_hit,
  input logic                    hdr_stb,
  input logic                    load_edge,
  input logic [CH_N*CODE_W-1:0]  act_code,
  input logic [CH_N*CODE_W-1:0]  stage_flat,
  input logic [CH_N-1:0]         pd_on,
  input logic                    spi_out_en,
  input logic [CODE_W-1:0]       rd_data
);

  logic              is_bcast;
  logic              is_read;
  logic [CODE_W-1:0] hdr_pick;

  assign is_bcast = (cmd_word[21:20] == 2'b11);
  assign is_read  = cmd_word[19] && !cmd_word[21];
  assign hdr_pick = act_code[cmd_word[18:17]*CODE_W +: CODE_W];

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    load_edge |=> (act_code == stage_flat)) else $error("load copy"); // R11

  AST_LOAD_PD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    load_edge |=> (pd_on == '0)) else $error("load clears pd"); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_stb && !load_edge) |=> ($stable(act_code) && $stable(stage_flat)
      && $stable(pd_on) && $stable(spi_out_en))) else $error("idle hold"); // R5

  AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !is_bcast && !addr_hit) |=> ($stable(stage_flat) && $stable(spi_out_en)))
    else $error("mismatch ignored"); // R5

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && is_read && !load_edge) |=> ($stable(act_code) && $stable(stage_flat)
      && $stable(pd_on))) else $error("read changes state"); // R5

  AST_PD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !is_bcast && addr_hit && !is_read && cmd_word[16] && !load_edge)
      |=> pd_on[$past(cmd_word[18:17])]) else $error("pd one"); // R6

  AST_PD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && is_bcast && cmd_word[18:17] == 2'b10 && !load_edge)
      |=> (pd_on == '1)) else $error("pd all"); // R9

  AST_SPI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && is_bcast && cmd_word[18:17] == 2'b11)
      |=> (spi_out_en == $past(cmd_word[16]))) else $error("spi set"); // R10

  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_stb |=> (rd_data == $past(hdr_pick))) else $error("readback"); // R12

endmodule

bind dac_cmd_bank dac_cmd_bank_chk #(.CH_N(CH_N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_word   (cmd_word),
  .cmd_stb    (cmd_stb),
  .addr_hit   (addr_hit),
  .hdr_stb    (hdr_stb),
  .load_edge  (load_edge),
  .act_code   (act_code),
  .stage_flat (stage_flat),
  .pd_on      (pd_on),
  .spi_out_en (spi_out_en),
  .rd_data    (rd_data)
);

// File: tb/dac_cmd_bank_tb_top.sv
`timescale 1ns/1ps
module dac_cmd_bank_tb_top;

  logic        clk;
  logic        rst_n;
  logic [21:0] cmd_word;
  logic        cmd_stb;
  logic        addr_hit;
  logic        hdr_stb;
  logic        load_pin;
  logic [63:0] act_code;
  logic [3:0]  pd_on;
  logic [7:0]  pd_mode;
  logic        spi_out_en;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] m_stage [4];
  logic [15:0] m_live  [4];
  logic        m_pd    [4];
  logic [1:0]  m_mode  [4];
  logic        m_spi;
  logic [15:0] m_rd;

  dac_cmd_bank dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_word   (cmd_word),
    .cmd_stb    (cmd_stb),
    .addr_hit   (addr_hit),
    .hdr_stb    (hdr_stb),
    .load_pin   (load_pin),
    .act_code   (act_code),
    .pd_on      (pd_on),
    .pd_mode    (pd_mode),
    .spi_out_en (spi_out_en),
    .rd_data    (rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [21:0] mk(input logic [1:0] ls, input logic rd,
                                     input logic [1:0] sel, input logic pd,
                                     input logic [15:0] data);
    return {ls, rd, sel, pd, data};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 4; i++) begin
      chk(req, $sformatf("live[%0d]", i), act_code[i*16 +: 16], m_live[i]);
      chk(req, $sformatf("pd[%0d]", i), {15'd0, pd_on[i]}, {15'd0, m_pd[i]});
      chk(req, $sformatf("mode[%0d]", i), {14'd0, pd_mode[i*2 +: 2]}, {14'd0, m_mode[i]});
    end
    chk(req, "spi_en", {15'd0, spi_out_en}, {15'd0, m_spi});
    chk(req, "rd_data", rd_data, m_rd);
  endtask

  task automatic model_cmd(input logic [21:0] w, input logic hit);
    logic [1:0]  ls   = w[21:20];
    logic        rd   = w[19];
    logic [1:0]  sel  = w[18:17];
    logic        pd   = w[16];
    logic [15:0] data = w[15:0];
    if (ls == 2'b11) begin
      case (sel)
        2'b00: for (int i = 0; i < 4; i++) begin m_live[i] = m_stage[i]; m_pd[i] = 0; end
        2'b01: for (int i = 0; i < 4; i++) begin
                 m_stage[i] = data; m_live[i] = data; m_pd[i] = 0;
               end
        2'b10: for (int i = 0; i < 4; i++) begin m_pd[i] = 1; m_mode[i] = data[15:14]; end
        default: m_spi = pd;
      endcase
    end else if (hit && !(rd && ls != 2'b10)) begin
      if (pd) begin
        m_pd[sel] = 1;
        m_mode[sel] = data[15:14];
      end else begin
        m_stage[sel] = data;
        if (ls == 2'b01) begin
          m_live[sel] = data; m_pd[sel] = 0;
        end else if (ls == 2'b10) begin
          for (int i = 0; i < 4; i++) begin m_live[i] = m_stage[i]; m_pd[i] = 0; end
        end
      end
    end
  endtask

  task automatic model_copy();
    for (int i = 0; i < 4; i++) begin
      m_live[i] = m_stage[i];
      m_pd[i]   = 0;
    end
  endtask

  task automatic do_cmd(input logic [21:0] w, input logic hit, input logic hdr,
                        input string req);
    @(negedge clk);
    cmd_word = w; cmd_stb = 1'b1; addr_hit = hit; hdr_stb = hdr;
    @(posedge clk);
    if (hdr) m_rd = m_live[w[18:17]];
    model_cmd(w, hit);
    @(negedge clk);
    cmd_stb = 1'b0; hdr_stb = 1'b0; addr_hit = 1'b0;
    check_all(req);
  endtask

  task automatic do_hdr(input logic [1:0] sel, input string req);
    @(negedge clk);
    cmd_word = mk(2'b00, 1'b1, sel, 1'b0, 16'h0); hdr_stb = 1'b1;
    @(posedge clk);
    m_rd = m_live[sel];
    @(negedge clk);
    hdr_stb = 1'b0;
    check_all(req);
  endtask

  task automatic pulse_load(input string req);
    @(negedge clk);
    load_pin = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check_all({req, " before copy"});
    @(posedge clk);
    model_copy();
    @(negedge clk);
    check_all(req);
    load_pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic load_with_cmd(input logic [21:0] w, input logic hit, input string req);
    @(negedge clk);
    load_pin = 1'b1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_word = w; cmd_stb = 1'b1; addr_hit = hit;
    @(posedge clk);
    model_cmd(w, hit);
    model_copy();
    @(negedge clk);
    cmd_stb = 1'b0; addr_hit = 1'b0;
    check_all(req);
    load_pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_0042);
    rst_n = 1'b0; cmd_word = '0; cmd_stb = 0; addr_hit = 0; hdr_stb = 0; load_pin = 0;
    for (int i = 0; i < 4; i++) begin
      m_stage[i] = '0; m_live[i] = '0; m_pd[i] = 0; m_mode[i] = '0;
    end
    m_spi = 0; m_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R2: stage-only write leaves live codes alone
    do_cmd(mk(2'b00, 0, 2'b10, 0, 16'h1234), 1, 0, "R2 stage C");
    chk("R2", "live C literal", act_code[47:32], 16'h0000);
    pulse_load("R11 load after stage");
    chk("R11", "live C literal", act_code[47:32], 16'h1234);

    // R3: each channel select code
    do_cmd(mk(2'b01, 0, 2'b00, 0, 16'hA001), 1, 0, "R3 ch A");
    do_cmd(mk(2'b01, 0, 2'b01, 0, 16'hB002), 1, 0, "R3 ch B");
    do_cmd(mk(2'b01, 0, 2'b10, 0, 16'hBEEF), 1, 0, "R3 ch C");
    do_cmd(mk(2'b01, 0, 2'b11, 0, 16'hFFFF), 1, 0, "R3 ch D");
    chk("R3", "live C literal", act_code[47:32], 16'hBEEF);

    // R4: stage others then load all together
    do_cmd(mk(2'b00, 0, 2'b00, 0, 16'h0101), 1, 0, "R2 stage A");
    do_cmd(mk(2'b10, 0, 2'b11, 0, 16'h0404), 1, 0, "R4 load all");
    chk("R4", "live A literal", act_code[15:0], 16'h0101);

    // R5: mismatch, read, and load-select 10 ignores bit 19
    do_cmd(mk(2'b01, 0, 2'b01, 0, 16'h5555), 0, 0, "R5 mismatch");
    do_cmd(mk(2'b01, 1, 2'b01, 0, 16'h6666), 1, 0, "R5 read");
    do_cmd(mk(2'b00, 1, 2'b01, 0, 16'h6767), 1, 0, "R5 read stage");
    do_cmd(mk(2'b10, 1, 2'b01, 0, 16'h7777), 1, 0, "R5 ls10 write");
    chk("R5", "live B literal", act_code[31:16], 16'h7777);

    // R6, R7: power-down one channel, then update clears it
    do_cmd(mk(2'b00, 0, 2'b10, 1, 16'h8000), 1, 0, "R6 pd C");
    do_cmd(mk(2'b01, 0, 2'b01, 1, 16'h4000), 1, 0, "R6 pd B");
    do_cmd(mk(2'b01, 0, 2'b10, 0, 16'h0C0C), 1, 0, "R7 update clears C");

    // R8, R9, R10: broadcasts with mismatched address
    do_cmd(mk(2'b00, 0, 2'b00, 0, 16'h9999), 1, 0, "R2 stage A");
    do_cmd(mk(2'b11, 0, 2'b00, 0, 16'h0000), 0, 0, "R8 bcast from stage");
    do_cmd(mk(2'b11, 0, 2'b01, 0, 16'h3C3C), 0, 0, "R8 bcast data");
    do_cmd(mk(2'b11, 0, 2'b10, 0, 16'hC000), 0, 0, "R9 bcast pd");
    pulse_load("R7 load clears pd");
    do_cmd(mk(2'b11, 0, 2'b11, 1, 16'h0000), 0, 0, "R10 spi on");
    do_cmd(mk(2'b11, 0, 2'b11, 0, 16'h0000), 0, 0, "R10 spi off");
    do_cmd(mk(2'b11, 0, 2'b11, 1, 16'h0000), 1, 0, "R10 spi on again");

    // R12: readback, also with a command in the same cycle
    do_cmd(mk(2'b01, 0, 2'b11, 0, 16'hD00D), 1, 0, "R3 ch D");
    do_hdr(2'b11, "R12 readback D");
    chk("R12", "rd literal", rd_data, 16'hD00D);
    do_cmd(mk(2'b01, 0, 2'b11, 0, 16'hE00E), 1, 1, "R12 readback before write");
    chk("R12", "rd literal old", rd_data, 16'hD00D);

    // R11: command and load edge in the same cycle
    load_with_cmd(mk(2'b00, 0, 2'b00, 0, 16'h1A1A), 1, "R11 same cycle stage");
    load_with_cmd(mk(2'b00, 0, 2'b01, 1, 16'h4000), 1, "R11 same cycle pd");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [21:0] w;
      logic        hit;
      logic        hdr;
      w   = 22'($urandom);
      hit = 1'($urandom);
      hdr = ($urandom % 4) == 0;
      do_cmd(w, hit, hdr, "R3 R8 random");
      if (($urandom % 16) == 0) pulse_load("R11 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule